// File: doc/BRIEF.md
# Cascadable Serial Multi-Channel DAC Code Loader

This block is the digital front end of a multi-channel 6-bit digital-to-analog converter. A host drives three slow pins: a serial data line, a shift clock and an active-low enable. While the enable is low, each falling shift-clock edge pushes one bit into a chain of 6-bit words, one word per channel. When the enable returns high, the whole chain is copied in a single step into holding registers. Those registers drive the per-channel codes. The analog network and its buffers are outside this block.

The whole design runs on one system clock. The three pins pass through multi-flop synchronizers. A model of a transparent latch gates the synchronized shift clock with the enable, and edge detectors turn the gated clock and the enable into single-cycle shift and load strobes. The bit at the far end of the chain is brought out on a serial output. Feeding that output into the data input of a second loader extends the chain across devices. The channel count is a parameter: six by default, four as the alternative.

Top module: `serdac_loader`

## Requirements
- R1: Bits are captured on the falling edge of the shift clock. Each channel word is shifted in most significant bit first, so the first bit of a word ends up in bit 5 of that channel's code.
- R2: The last word shifted before a load drives channel 1 (`ch_code_o[5:0]`). Each earlier word drives the next higher channel, so channel k sits at `ch_code_o[6k-1:6k-6]`.
- R3: While the enable is high, shift-clock edges do not move the chain. Serial output and codes are unchanged by them.
- R4: The internal gated clock follows the shift clock while the enable is low. While the enable is high, it holds the level it had when the enable rose. A falling transition of this gated clock is a shift, including one caused by lowering the enable while the gated clock holds high and the pin is low. Lowering the enable while both are low causes no shift.
- R5: The channel codes change only on the rising edge of the enable. At that edge all channels take the chain contents at once, and they stay unchanged while bits are being shifted.
- R6: A full update takes 6×N shift clocks. A load of 6×k clocks (k < N) puts fresh words in channels 1..k, and channels k+1..N take the older chain words pushed up by 6×k places.
- R7: The serial output is the bit at the far end of the chain (the first bit of the word for channel N). It changes only after a shift edge, so after 6×N further shifts it shows the first bit of that sequence.
- R8: A synchronous active-high reset clears the chain, the serial output and all channel codes to 0.
- R9: With N = 4, the loader behaves the same way with a 24-bit chain. Cascaded behind a six-channel loader, it receives the bits that leave that loader's chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous, falling edge shifts) |
| ser_en_n_i | input | 1 | Active-low load enable (asynchronous, rising edge loads) |
| ser_din_i | input | 1 | Serial data in |
| ser_dout_o | output | 1 | Far end of the chain, for cascading |
| ch_code_o | output | 6×N_CH | Channel codes, channel 1 in bits [5:0] |

## Verification
The bench goes after the gating corner cases. These are the enable rising with the shift clock low and then dropping with it still low, and the enable rising with the clock high and dropping after the clock fell. A design without the gating latch would add or lose a bit, which shifts every channel word by one place. Short loads check that the upper channels receive the shifted-up old words; a design that cleared or skipped them would show zeros or stale codes. Clocks pulsed while the enable is high, and codes sampled in the middle of a transfer, catch designs that shift or update outside a load. A cascaded four-channel loader checks that the serial output carries the right far-end bit at the right time.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

   localparam int unsigned CODE_W_DEF = 6;

   typedef struct packed {
      logic shift;
      logic load;
   } strobe_t;

   function automatic int unsigned chain_bits(input int unsigned n_ch, input int unsigned w);
      return n_ch * w;
   endfunction

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("serdac_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/serdac_gate.sv
module serdac_gate
   import serdac_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    sclk_s,
   input  logic    en_n_s,
   output strobe_t stb
);

   logic g_q;
   logic gated;
   logic en_q;

   // Transparent while enable is low, holding its last level while high.
   assign gated = en_n_s ? g_q : sclk_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         g_q  <= 1'b1;
         en_q <= 1'b1;
      end else begin
         g_q  <= gated;
         en_q <= en_n_s;
      end
   end

   assign stb.shift = g_q & ~gated;
   assign stb.load  = en_n_s & ~en_q;

   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({stb.shift, stb.load}));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (en_n_s && $past(en_n_s)) |=> $stable(g_q));

endmodule

// File: rtl/serdac_chain.sv
module serdac_chain #(
   parameter int unsigned TOT = 36
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift,
   input  logic           din,
   output logic [TOT-1:0] sr,
   output logic           dout
);

   if (TOT < 2) begin : g_bad_len
      $error("serdac_chain: TOT must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)        sr <= '0;
      else if (shift) sr <= {sr[TOT-2:0], din};
   end

   assign dout = sr[TOT-1];

   p_capture_r1: assert property (@(posedge clk) disable iff (rst)
      shift |=> sr[0] == $past(din));

   p_dout_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(dout));

endmodule

// File: rtl/serdac_bank.sv
module serdac_bank #(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned CODE_W = 6,
   localparam int unsigned TOT   = N_CH * CODE_W
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [TOT-1:0] sr,
   output logic [TOT-1:0] codes
);

   for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (rst)       codes[c*CODE_W +: CODE_W] <= '0;
         else if (load) codes[c*CODE_W +: CODE_W] <= sr[c*CODE_W +: CODE_W];
      end
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(codes));

   p_copy_r5: assert property (@(posedge clk) disable iff (rst)
      load |=> codes == $past(sr));

endmodule

// File: rtl/serdac_loader.sv
module serdac_loader
   import serdac_pkg::*;
#(
   parameter int unsigned N_CH        = 6,
   parameter int unsigned CODE_W      = CODE_W_DEF,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned TOT        = chain_bits(N_CH, CODE_W)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ser_clk_i,
   input  logic           ser_en_n_i,
   input  logic           ser_din_i,
   output logic           ser_dout_o,
   output logic [TOT-1:0] ch_code_o
);

   if (N_CH < 1 || N_CH > 16) begin : g_bad_nch
      $error("serdac_loader: N_CH must be 1..16");
   end
   if (CODE_W < 1) begin : g_bad_w
      $error("serdac_loader: CODE_W must be positive");
   end

   logic    sclk_s, en_n_s, din_s;
   strobe_t stb;
   logic [TOT-1:0] sr;

   // Clock and enable idle high; all three share one synchronizer depth.
   serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ser_clk_i, ser_en_n_i, ser_din_i}),
      .q   ({sclk_s, en_n_s, din_s})
   );

   serdac_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .sclk_s (sclk_s),
      .en_n_s (en_n_s),
      .stb    (stb)
   );

   serdac_chain #(.TOT(TOT)) u_chain (
      .clk   (clk),
      .rst   (rst),
      .shift (stb.shift),
      .din   (din_s),
      .sr    (sr),
      .dout  (ser_dout_o)
   );

   serdac_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .load  (stb.load),
      .sr    (sr),
      .codes (ch_code_o)
   );

   p_no_shift_disabled_r3: assert property (@(posedge clk) disable iff (rst)
      en_n_s |=> $stable(sr));

   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (ch_code_o == '0 && ser_dout_o == 1'b0));

endmodule

// File: tb/serdac_loader_test.sv
module serdac_loader_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b1;
   logic en_n = 1'b1;
   logic din = 1'b0;
   logic dout6, dout4;
   logic [35:0] code6;
   logic [23:0] code4;

   int checks = 0;
   int errors = 0;

   logic [35:0] m_sr6 = '0, m_cd6 = '0;
   logic [23:0] m_sr4 = '0, m_cd4 = '0;

   always #10 clk = ~clk;

   serdac_loader uut (
      .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_en_n_i(en_n), .ser_din_i(din),
      .ser_dout_o(dout6), .ch_code_o(code6));

   serdac_loader #(.N_CH(4)) uut4 (
      .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_en_n_i(en_n), .ser_din_i(dout6),
      .ser_dout_o(dout4), .ch_code_o(code4));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_shift(input logic b);
      m_sr4 = {m_sr4[22:0], m_sr6[35]};
      m_sr6 = {m_sr6[34:0], b};
   endtask

   task automatic model_load();
      m_cd6 = m_sr6;
      m_cd4 = m_sr4;
   endtask

   task automatic check_codes(input string tag);
      for (int c = 0; c < 6; c++)
         chk($sformatf("%s ch%0d", tag, c + 1), int'(code6[c*6 +: 6]), int'(m_cd6[c*6 +: 6]));
      for (int c = 0; c < 4; c++)
         chk($sformatf("%s cascade ch%0d", tag, c + 1), int'(code4[c*6 +: 6]), int'(m_cd4[c*6 +: 6]));
   endtask

   task automatic send_bit(input logic b, input bit chk_out);
      din = b;
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(8);
      sclk = 1'b1;
      model_shift(b);
      if (chk_out) chk("R7 serial out", int'(dout6), int'(m_sr6[35]));
      wait_cyc(8);
   endtask

   task automatic send_word(input logic [5:0] w, input bit chk_out);
      for (int i = 5; i >= 0; i--) send_bit(w[i], chk_out);
   endtask

   task automatic begin_xfer();
      en_n = 1'b0;
      wait_cyc(8);
   endtask

   task automatic end_xfer();
      en_n = 1'b1;
      model_load();
      wait_cyc(8);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      wait_cyc(3);
      rst = 1'b0;
      m_sr6 = '0; m_sr4 = '0; m_cd6 = '0; m_cd4 = '0;
      wait_cyc(4);
      chk("R8 codes after reset", int'(code6 == '0), 1);
      chk("R8 cascade codes after reset", int'(code4 == '0), 1);
      chk("R8 serial out after reset", int'(dout6), 0);
   endtask

   task automatic t_full_load();
      logic [35:0] snap;
      snap = code6;
      begin_xfer();
      // First word goes to channel 6, last to channel 1 (R2).
      for (int c = 6; c >= 1; c--) begin
         send_word(6'(c * 9 + 5), 1'b0);
         if (c == 4) chk("R5 codes steady mid-shift", int'(code6 == snap), 1);
      end
      chk("R5 codes steady before enable rise", int'(code6 == snap), 1);
      end_xfer();
      check_codes("R1 R2 full load");
      chk("R2 ch1 holds last word", int'(code6[5:0]), 14);
      chk("R2 ch6 holds first word", int'(code6[35:30]), 59);
   endtask

   task automatic t_short_load();
      logic [5:0] old_ch1;
      old_ch1 = m_cd6[5:0];
      begin_xfer();
      send_word(6'h2A, 1'b0);
      send_word(6'h15, 1'b0);
      end_xfer();
      check_codes("R6 short load");
      chk("R6 ch1 fresh", int'(code6[5:0]), 6'h15);
      chk("R6 ch3 takes old ch1", int'(code6[17:12]), int'(old_ch1));
   endtask

   task automatic t_enable_high();
      logic d_before;
      d_before = dout6;
      for (int i = 0; i < 8; i++) begin
         din = i[0];
         wait_cyc(4);
         sclk = 1'b0;
         wait_cyc(8);
         sclk = 1'b1;
         wait_cyc(8);
      end
      chk("R3 serial out unchanged", int'(dout6), int'(d_before));
      begin_xfer();
      end_xfer();
      check_codes("R3 clocks ignored while disabled");
   endtask

   task automatic t_gate_low_low();
      begin_xfer();
      send_word(6'h3F, 1'b0);
      din = 1'b0;
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(8);
      model_shift(1'b0);
      en_n = 1'b1;
      model_load();
      wait_cyc(8);
      din = 1'b1;
      sclk = 1'b1;
      wait_cyc(8);
      sclk = 1'b0;
      wait_cyc(8);
      en_n = 1'b0;
      wait_cyc(8);
      sclk = 1'b1;
      wait_cyc(8);
      end_xfer();
      check_codes("R4 enable dropped with clock low, no shift");
   endtask

   task automatic t_gate_high_low();
      begin_xfer();
      send_word(6'h00, 1'b0);
      end_xfer();
      din = 1'b1;
      sclk = 1'b0;
      wait_cyc(8);
      en_n = 1'b0;
      model_shift(1'b1);
      wait_cyc(8);
      sclk = 1'b1;
      wait_cyc(8);
      end_xfer();
      check_codes("R4 enable dropped after clock fell, one shift");
      chk("R4 ch1 gained one bit", int'(code6[5:0]), 1);
   endtask

   task automatic t_cascade();
      begin_xfer();
      for (int c = 0; c < 10; c++) send_word(6'(c * 7 + 3), 1'b1);
      end_xfer();
      check_codes("R9 cascade 60 bits");
      chk("R9 far channel of second device", int'(code4[23:18]), 3);
      chk("R7 serial out after full pass", int'(dout6), int'(m_sr6[35]));
   endtask

   initial begin
      wait_cyc(150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(2);
      t_reset();
      t_full_load();
      t_short_load();
      t_enable_high();
      t_gate_low_low();
      t_gate_high_low();
      t_cascade();
      t_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule